// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which message buffer a CAN-style controller sends next. A bank of buffers is presented on flat input vectors. Each buffer has a 4-bit state code, a 32-bit comparison key and a 3-bit local priority. The key already carries the RTR and IDE bits at their frame positions. A scan visits one buffer per clock, from index 0 upward. Buffers whose code does not mark them as active transmit buffers are skipped. The scan keeps the best candidate seen so far.

Two control inputs choose the ordering:
- With `lbuf_first_i` set, the lowest index wins.
- With both inputs clear, the smallest key wins.
- With only `lprio_en_i` set, the local priority is placed in front of the key before the compare.

In every mode a tie goes to the lower index.

Scans are started by frame-phase strobes from the protocol engine and by control-word write strobes. When the last buffer has been visited, the block pulses `done_o`. It also updates a held found flag and the winning index.

Top module: `txmb_arbiter`

## Requirements
- R1: Only a buffer whose code equals 4'b1100 can win. A buffer with any other code is skipped, whatever its key or priority.
- R2: With `lbuf_first_i`=1, the eligible buffer with the smallest index wins, and `lprio_en_i` has no effect.
- R3: With `lbuf_first_i`=0 and `lprio_en_i`=0, the eligible buffer with the numerically smallest 32-bit key wins.
- R4: With `lbuf_first_i`=0 and `lprio_en_i`=1, buffers are ranked by the 35-bit value {priority, key}. Priority 3'b000 is the most urgent.
- R5: When two eligible buffers have an equal compare value, the lower index wins.
- R6: All 32 key bits take part in the compare, from bit 31 (most significant) down to bit 0. The RTR/IDE bits are placed inside the key by the caller.
- R7: A one-cycle pulse on `crc_phase_i` or `err_delim_i` starts a scan.
- R8: `intermission_i` starts a scan only when no scan is running and one of two conditions holds:
  - the last result found a winner whose code is no longer 4'b1100, or
  - the last result found nothing and `cs_write_i` pulsed while idle since the last scan began.
- R9: `cs_write_i` starts a scan at once when `bus_idle_i`=1, but not when `bus_idle_i`=0. A pulse on `freeze_exit_i` also starts a scan.
- R10: `done_o` is a single-cycle pulse N clock edges after the edge that samples the start event. `found_o` and `win_idx_o` hold their values until the next `done_o`.
- R11: A start event that arrives during a scan restarts the scan from buffer 0. No `done_o` is produced for the abandoned scan.
- R12: A scan with no eligible buffer reports `found_o`=0 and `win_idx_o`=0.
- R13: After reset, `done_o`, `found_o` and `win_idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lbuf_first_i | input | 1 | Lowest-index ordering select |
| lprio_en_i | input | 1 | Prefix local priority to key |
| crc_phase_i | input | 1 | Frame in CRC field strobe |
| err_delim_i | input | 1 | Frame in error delimiter strobe |
| intermission_i | input | 1 | Frame in intermission strobe |
| bus_idle_i | input | 1 | Controller idle or bus-off |
| cs_write_i | input | 1 | CPU wrote a buffer control word |
| freeze_exit_i | input | 1 | Controller leaving freeze mode |
| mb_code_i | input | 4*N_MB | State code per buffer, buffer i at [4i+:4] |
| mb_key_i | input | 32*N_MB | Compare key per buffer, buffer i at [32i+:32] |
| mb_prio_i | input | 3*N_MB | Local priority per buffer, buffer i at [3i+:3] |
| done_o | output | 1 | Scan complete pulse |
| found_o | output | 1 | Last scan found a candidate |
| win_idx_o | output | $clog2(N_MB) | Winning buffer index |

## Verification
The bench builds the block with N_MB=6. Six is not a power of two, so the index counter must stop at 5 and not wrap through 7. The short bank still reaches every corner case:
- a winner in the first slot and in the last slot;
- the two ends of the 32-bit key;
- a restart in the middle of a scan.

The scan length is short enough to confirm exact done latency after every start source.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int CODE_W = 4;
  localparam int KEY_W  = 32;
  localparam int PRIO_W = 3;
  localparam int CMP_W  = KEY_W + PRIO_W;
  localparam logic [CODE_W-1:0] CODE_TX_ACTIVE = 4'b1100;

  typedef enum logic [1:0] {
    ORD_INDEX   = 2'd0,
    ORD_KEY     = 2'd1,
    ORD_PRIOKEY = 2'd2
  } order_e;

  function automatic order_e order_sel(input logic lbuf, input logic lprio);
    if (lbuf)       return ORD_INDEX;
    else if (lprio) return ORD_PRIOKEY;
    else            return ORD_KEY;
  endfunction
endpackage

// File: rtl/tx_arb_cmp.sv
module tx_arb_cmp
  import tx_arb_pkg::*;
(
  input  order_e              ord_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [PRIO_W-1:0]   prio_i,
  input  logic                best_valid_i,
  input  logic [CMP_W-1:0]    best_key_i,
  output logic                take_o,
  output logic [CMP_W-1:0]    cand_key_o
);
  logic eligible;
  logic better;

  always_comb begin
    unique case (ord_i)
      ORD_PRIOKEY: cand_key_o = {prio_i, key_i};
      ORD_KEY:     cand_key_o = {{PRIO_W{1'b0}}, key_i};
      default:     cand_key_o = '0; // index order: all equal, first eligible stays
    endcase
  end

  assign eligible = (code_i == CODE_TX_ACTIVE);
  // strict less keeps the lower index on ties
  assign better   = cand_key_o < best_key_i;
  assign take_o   = eligible && (!best_valid_i || better);
endmodule

// File: rtl/tx_arb_trig.sv
module tx_arb_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic crc_phase_i,
  input  logic err_delim_i,
  input  logic intermission_i,
  input  logic bus_idle_i,
  input  logic cs_write_i,
  input  logic freeze_exit_i,
  input  logic last_found_i,
  input  logic last_win_active_i,
  output logic start_o
);
  logic wr_pend_q;
  logic hard_start;
  logic inter_start;

  assign hard_start  = crc_phase_i | err_delim_i | freeze_exit_i | (bus_idle_i & cs_write_i);
  assign inter_start = intermission_i & ~busy_i &
                       (last_found_i ? ~last_win_active_i : wr_pend_q);
  assign start_o     = hard_start | inter_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wr_pend_q <= 1'b0;
    else if (start_o)            wr_pend_q <= 1'b0;
    else if (cs_write_i && !busy_i) wr_pend_q <= 1'b1;
  end

  // R8
  inter_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !crc_phase_i && !err_delim_i && !freeze_exit_i && !(bus_idle_i && cs_write_i))
      |-> !start_o);
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
  import tx_arb_pkg::*;
#(
  parameter int N_MB = 16,
  localparam int IW  = (N_MB > 1) ? $clog2(N_MB) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lbuf_first_i,
  input  logic                 lprio_en_i,
  input  logic                 crc_phase_i,
  input  logic                 err_delim_i,
  input  logic                 intermission_i,
  input  logic                 bus_idle_i,
  input  logic                 cs_write_i,
  input  logic                 freeze_exit_i,
  input  logic [4*N_MB-1:0]    mb_code_i,
  input  logic [32*N_MB-1:0]   mb_key_i,
  input  logic [3*N_MB-1:0]    mb_prio_i,
  output logic                 done_o,
  output logic                 found_o,
  output logic [IW-1:0]        win_idx_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_MB - 1);

  logic [CODE_W-1:0] code_a [N_MB];
  logic [KEY_W-1:0]  key_a  [N_MB];
  logic [PRIO_W-1:0] prio_a [N_MB];

  for (genvar g = 0; g < N_MB; g++) begin : g_unpack
    assign code_a[g] = mb_code_i[g*CODE_W +: CODE_W];
    assign key_a[g]  = mb_key_i[g*KEY_W +: KEY_W];
    assign prio_a[g] = mb_prio_i[g*PRIO_W +: PRIO_W];
  end

  logic             busy_q, best_valid_q, done_q, found_q;
  logic [IW-1:0]    idx_q, best_idx_q, win_q;
  logic [CMP_W-1:0] best_key_q;
  logic             start, take, last;
  logic [CMP_W-1:0] cand_key;
  logic             last_win_active;
  order_e           ord;

  assign ord             = order_sel(lbuf_first_i, lprio_en_i);
  assign last            = (idx_q == LAST_IDX);
  assign last_win_active = (code_a[win_q] == CODE_TX_ACTIVE);

  tx_arb_trig u_trig (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .busy_i            (busy_q),
    .crc_phase_i       (crc_phase_i),
    .err_delim_i       (err_delim_i),
    .intermission_i    (intermission_i),
    .bus_idle_i        (bus_idle_i),
    .cs_write_i        (cs_write_i),
    .freeze_exit_i     (freeze_exit_i),
    .last_found_i      (found_q),
    .last_win_active_i (last_win_active),
    .start_o           (start)
  );

  tx_arb_cmp u_cmp (
    .ord_i        (ord),
    .code_i       (code_a[idx_q]),
    .key_i        (key_a[idx_q]),
    .prio_i       (prio_a[idx_q]),
    .best_valid_i (best_valid_q),
    .best_key_i   (best_key_q),
    .take_o       (take),
    .cand_key_o   (cand_key)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      idx_q        <= '0;
      best_valid_q <= 1'b0;
      best_key_q   <= '0;
      best_idx_q   <= '0;
      done_q       <= 1'b0;
      found_q      <= 1'b0;
      win_q        <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q       <= 1'b1;
        idx_q        <= '0;
        best_valid_q <= 1'b0;
        best_key_q   <= '0;
        best_idx_q   <= '0;
      end else if (busy_q) begin
        if (take) begin
          best_valid_q <= 1'b1;
          best_key_q   <= cand_key;
          best_idx_q   <= idx_q;
        end
        if (last) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          found_q <= best_valid_q | take;
          win_q   <= take ? idx_q : best_idx_q;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign done_o    = done_q;
  assign found_o   = found_q;
  assign win_idx_o = win_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= LAST_IDX));
  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_q && idx_q == '0 && !done_o));
  // R12
  no_winner_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (win_idx_o == '0));
  // R1
  winner_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && take) |-> (code_a[idx_q] == CODE_TX_ACTIVE));
endmodule

// File: tb/sim_txmb_arbiter.sv
module sim_txmb_arbiter;
  localparam int N  = 6;
  localparam int IW = $clog2(N);
  localparam logic [3:0] ACT = 4'b1100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lbuf = 0, lprio = 0, crc = 0, errd = 0, inter = 0, idle = 0, csw = 0, frz = 0;
  logic [3:0]  code [N];
  logic [31:0] key  [N];
  logic [2:0]  prio [N];
  logic [4*N-1:0]  mb_code;
  logic [32*N-1:0] mb_key;
  logic [3*N-1:0]  mb_prio;
  logic done, found;
  logic [IW-1:0] win;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mb_code[i*4 +: 4]  = code[i];
      mb_key[i*32 +: 32] = key[i];
      mb_prio[i*3 +: 3]  = prio[i];
    end
  end

  txmb_arbiter #(.N_MB(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lbuf_first_i(lbuf), .lprio_en_i(lprio),
    .crc_phase_i(crc), .err_delim_i(errd), .intermission_i(inter),
    .bus_idle_i(idle), .cs_write_i(csw), .freeze_exit_i(frz),
    .mb_code_i(mb_code), .mb_key_i(mb_key), .mb_prio_i(mb_prio),
    .done_o(done), .found_o(found), .win_idx_o(win)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mbs();
    for (int i = 0; i < N; i++) begin
      code[i] = 4'h0; key[i] = 32'hFFFF_FFFF; prio[i] = 3'd7;
    end
  endtask

  // 0 crc, 1 err delim, 2 intermission, 3 cs write, 4 freeze exit
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: crc = 1; 1: errd = 1; 2: inter = 1; 3: csw = 1; default: frz = 1;
    endcase
    @(negedge clk);
    crc = 0; errd = 0; inter = 0; csw = 0; frz = 0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = -1;
    for (int c = 1; c <= 4*N; c++) begin
      if (done) begin cnt = c - 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic expect_scan(input string req, input int src, input int f, input int w);
    int cnt;
    pulse(src);
    @(negedge clk);
    wait_done(cnt);
    cnt = (cnt < 0) ? -1 : cnt + 1;
    check({req, " latency"}, cnt, N);
    check({req, " found"}, int'(found), f);
    check({req, " index"}, int'(win), w);
  endtask

  task automatic expect_quiet(input string req, input int src);
    int seen = 0;
    pulse(src);
    for (int c = 0; c < N + 3; c++) begin
      if (done) seen = 1;
      @(negedge clk);
    end
    check({req, " no scan"}, seen, 0);
  endtask

  task automatic t_reset();
    check("R13 done", int'(done), 0);
    check("R13 found", int'(found), 0);
    check("R13 win", int'(win), 0);
  endtask

  task automatic t_orders();
    clr_mbs();
    code[0] = 4'b1000; key[0] = 32'h0; prio[0] = 3'd0;   // inactive, best key
    code[1] = ACT; key[1] = 32'h500; prio[1] = 3'd3;
    code[3] = ACT; key[3] = 32'h100; prio[3] = 3'd5;
    code[4] = ACT; key[4] = 32'h200; prio[4] = 3'd1;
    lbuf = 1; lprio = 1;
    expect_scan("R2 lbuf", 0, 1, 1);
    lbuf = 0; lprio = 0;
    expect_scan("R3 R1 key", 0, 1, 3);
    lprio = 1;
    expect_scan("R4 prio", 0, 1, 4);
    prio[1] = 3'd0;
    expect_scan("R4 prio000", 0, 1, 1);
    lprio = 0;
  endtask

  task automatic t_ties_bits();
    clr_mbs();
    code[2] = ACT; key[2] = 32'h42; prio[2] = 3'd2;
    code[5] = ACT; key[5] = 32'h42; prio[5] = 3'd2;
    expect_scan("R5 tie key", 0, 1, 2);
    lprio = 1;
    expect_scan("R5 tie prio", 0, 1, 2);
    lprio = 0;
    key[5] = 32'h41;
    expect_scan("R3 last slot", 0, 1, 5);
    clr_mbs();
    code[1] = ACT; key[1] = 32'hA5A5_0001;
    code[3] = ACT; key[3] = 32'hA5A5_0000;
    expect_scan("R6 lsb", 0, 1, 3);
    clr_mbs();
    code[0] = ACT; key[0] = 32'h8000_0000;
    code[2] = ACT; key[2] = 32'h7FFF_FFFF;
    expect_scan("R6 msb", 0, 1, 2);
  endtask

  task automatic t_triggers();
    clr_mbs();
    code[2] = ACT; key[2] = 32'h5;
    expect_scan("R7 crc", 0, 1, 2);
    expect_scan("R7 errdelim", 1, 1, 2);
    expect_quiet("R8 winner still active", 2);
    code[2] = 4'h0; code[4] = ACT;
    expect_scan("R8 winner deactivated", 2, 1, 4);
    clr_mbs();
    expect_scan("R12 none", 0, 0, 0);
    expect_quiet("R8 no write", 2);
    code[1] = ACT;
    expect_quiet("R9 write not idle", 3);
    expect_scan("R8 pending write", 2, 1, 1);
    check("R10 held found", int'(found), 1);
    check("R10 held win", int'(win), 1);
    idle = 1;
    code[3] = ACT; key[3] = 32'h0;
    expect_scan("R9 idle write", 3, 1, 3);
    idle = 0;
    expect_scan("R9 freeze exit", 4, 1, 3);
  endtask

  task automatic t_restart();
    int cnt;
    clr_mbs();
    code[4] = ACT;
    pulse(0);
    @(negedge clk);
    check("R11 no early done", int'(done), 0);
    pulse(1);   // arrives mid-scan
    @(negedge clk);
    wait_done(cnt);
    cnt = (cnt < 0) ? -1 : cnt + 1;
    check("R11 restart latency", cnt, N);
    check("R11 index", int'(win), 4);
  endtask

  initial begin
    clr_mbs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_orders();
    t_ties_bits();
    t_triggers();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule